// File: doc/BRIEF.md
# Single-Block DMA Channel

This block is one DMA channel that copies one block of data from a source region to a destination region over a simple request/acknowledge memory bus. Software programs the configuration registers and then sets the enable bit. The configuration is the two start addresses, the block length in source units, the width and address mode of each side, a transfer-type code that marks each side as memory or peripheral, and the pacing choice for each peripheral side. While the channel runs, the enable bit reads 1, and software polls it to find an idle channel. When the last destination write is acknowledged, the enable bit drops and a completion flag raises `irq`. Reading the interrupt status register clears that flag, so software reads it once before programming to discard an old event.

Bytes travel from source to destination through a 4-byte holding register. Each side moves bytes, halfwords or words on its own, and the data is packed on the way in and unpacked on the way out. A peripheral side is paced either by one selected line of `hw_req` or by software request writes, one unit per request. A memory side is never paced. The channel runs only in single-buffer form: the enable write is refused unless both descriptor-fetch-disable bits are set.

The controller has four states. ST_IDLE goes to ST_ARB on an accepted enable. ST_ARB goes to ST_WR when the holding register holds a full destination unit and the destination may proceed. Failing that, ST_ARB goes to ST_RD when source units remain, a source unit fits in the holding register, and the source may proceed. ST_ARB goes back to ST_IDLE when the byte count is zero. ST_RD returns to ST_ARB on acknowledge. ST_WR returns to ST_ARB on acknowledge, or to ST_IDLE when that acknowledge completes the last write.

Top module: `dma_single_chan`

Register map (word index on `reg_addr`):
- 0: source start address.
- 1: destination start address.
- 2: transfer control, with these fields:
  - [11:0] block length in source units
  - [13:12] source width
  - [15:14] destination width
  - [17:16] source address mode
  - [19:18] destination address mode
  - [21:20] transfer type
  - [22] source descriptor-fetch disable
  - [23] destination descriptor-fetch disable
- 3: handshake, with these fields:
  - [0] source hardware select
  - [1] destination hardware select
  - [7:4] source line index
  - [11:8] destination line index
- 4: enable. Writing bit0 as 1 starts the channel; reading returns the enable bit in bit0.
- 5: software request. Writing bit0 requests a source unit; writing bit1 requests a destination unit.
- 6: interrupt status. Bit0 is the completion flag, cleared on read.

## Requirements
- R1: After reset the enable bit and the completion flag read 0, and `irq` and `mem_req` are low.
- R2: An enable write is accepted only when register 2 bits 22 and 23 are both 1. Otherwise the enable bit stays 0 and no bus access is made.
- R3: The channel moves the block length times the source width in bytes. Width code 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. Bytes arrive in the order read, packed little-endian and right-aligned on the bus, through a 4-byte holding register for any pair of widths whose byte total is a multiple of the destination width.
- R4: Each side's address starts at its start register. After each access it moves by that side's width in bytes: upward for mode 0, downward for mode 1, and not at all for mode 2.
- R5: A peripheral side with hardware select 1 starts each access only after the `hw_req` line chosen by its index field was high. Other lines have no effect. Transfer type 0 means memory to memory, 1 memory to peripheral, 2 peripheral to memory and 3 peripheral to peripheral.
- R6: A peripheral side with hardware select 0 performs exactly one unit per software request write to register 5.
- R7: A memory side proceeds without any request, whatever its handshake fields hold.
- R8: The enable bit reads 1 while the block runs. It clears in the same cycle the completion flag sets, when the last destination write is acknowledged, and `irq` follows the flag.
- R9: A read of register 6 returns the flag and clears it. If completion falls in the same cycle as that read, the read returns 0 and the flag stays set.
- R10: A bus request stays asserted with unchanged address, direction and write data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears interrupt status at index 6) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| hw_req | input | NPER | Hardware request lines from peripherals |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned, valid with ack |
| mem_ack | input | 1 | Access complete |
| irq | output | 1 | Completion interrupt |

## Verification
The two functions that can meet in one cycle are the clear-on-read of the interrupt status and the completion event that sets it. The bench holds a read of register 6 active on every cycle of a whole transfer, so the final acknowledge is bound to land on a read cycle. It then requires that exactly one of those reads returned 1. Zero ones would mean the clear won over the set, and two ones would mean the read did not clear.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } chan_state_e;

    localparam logic [1:0] MODE_INC = 2'd0;
    localparam logic [1:0] MODE_DEC = 2'd1;

    localparam logic [2:0] RIX_SRC  = 3'd0;
    localparam logic [2:0] RIX_DST  = 3'd1;
    localparam logic [2:0] RIX_XFER = 3'd2;
    localparam logic [2:0] RIX_HS   = 3'd3;
    localparam logic [2:0] RIX_EN   = 3'd4;
    localparam logic [2:0] RIX_SREQ = 3'd5;
    localparam logic [2:0] RIX_INT  = 3'd6;

    function automatic logic [2:0] unit_bytes(input logic [1:0] w);
        case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW      = 32,
    parameter int BSIZE_W = 12,
    parameter int PIDX_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [AW-1:0]      src_start,
    output logic [AW-1:0]      dst_start,
    output logic [BSIZE_W-1:0] bsize,
    output logic [1:0]         src_w,
    output logic [1:0]         dst_w,
    output logic [1:0]         src_mode,
    output logic [1:0]         dst_mode,
    output logic [1:0]         xtype,
    output logic               src_hw,
    output logic               dst_hw,
    output logic [PIDX_W-1:0]  src_idx,
    output logic [PIDX_W-1:0]  dst_idx,
    output logic               start,
    output logic               en,
    output logic               soft_src,
    output logic               soft_dst,
    input  logic               src_take,
    input  logic               dst_take,
    input  logic               done,
    output logic               irq
);

    logic snd_q, dnd_q, flag_q;
    logic [1:0] sreq_q;
    logic wr_en_reg, rd_int;

    assign wr_en_reg = reg_wr && (reg_addr == RIX_EN) && reg_wdata[0];
    assign start     = wr_en_reg && !en && snd_q && dnd_q;
    assign rd_int    = reg_rd && (reg_addr == RIX_INT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_start <= '0;
            dst_start <= '0;
            bsize     <= '0;
            src_w     <= '0;
            dst_w     <= '0;
            src_mode  <= '0;
            dst_mode  <= '0;
            xtype     <= '0;
            snd_q     <= 1'b0;
            dnd_q     <= 1'b0;
            src_hw    <= 1'b0;
            dst_hw    <= 1'b0;
            src_idx   <= '0;
            dst_idx   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RIX_SRC: src_start <= reg_wdata[AW-1:0];
                RIX_DST: dst_start <= reg_wdata[AW-1:0];
                RIX_XFER: begin
                    bsize    <= reg_wdata[BSIZE_W-1:0];
                    src_w    <= reg_wdata[13:12];
                    dst_w    <= reg_wdata[15:14];
                    src_mode <= reg_wdata[17:16];
                    dst_mode <= reg_wdata[19:18];
                    xtype    <= reg_wdata[21:20];
                    snd_q    <= reg_wdata[22];
                    dnd_q    <= reg_wdata[23];
                end
                RIX_HS: begin
                    src_hw  <= reg_wdata[0];
                    dst_hw  <= reg_wdata[1];
                    src_idx <= reg_wdata[4 +: PIDX_W];
                    dst_idx <= reg_wdata[8 +: PIDX_W];
                end
                default: ;
            endcase
        end
    end

    // enable bit, completion flag and software request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= 1'b0;
            flag_q <= 1'b0;
            sreq_q <= 2'b00;
        end else begin
            if (start)     en <= 1'b1;
            else if (done) en <= 1'b0;
            // completion set takes precedence over clear-on-read
            if (done)        flag_q <= 1'b1;
            else if (rd_int) flag_q <= 1'b0;
            sreq_q <= (sreq_q & ~{dst_take, src_take})
                    | ((reg_wr && reg_addr == RIX_SREQ) ? reg_wdata[1:0] : 2'b00);
        end
    end

    assign soft_src = sreq_q[0];
    assign soft_dst = sreq_q[1];
    assign irq      = flag_q;

    always_comb begin
        case (reg_addr)
            RIX_SRC:  reg_rdata = 32'(src_start);
            RIX_DST:  reg_rdata = 32'(dst_start);
            RIX_XFER: reg_rdata = 32'({dnd_q, snd_q, xtype, dst_mode, src_mode,
                                       dst_w, src_w, 12'(bsize)});
            RIX_HS:   reg_rdata = 32'({4'(dst_idx), 4'(src_idx), 2'b00, dst_hw, src_hw});
            RIX_EN:   reg_rdata = {31'd0, en};
            RIX_INT:  reg_rdata = {31'd0, flag_q};
            default:  reg_rdata = 32'd0;
        endcase
    end

    a_r8_en_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!en && flag_q));
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_int && !done) |=> !flag_q);
    a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_reg && !en && !(snd_q && dnd_q)) |=> !en);

endmodule

// File: rtl/dma_chan_addr_gen.sv
module dma_chan_addr_gen
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start_addr,
    input  logic          step,
    input  logic [1:0]    mode,
    input  logic [1:0]    width,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] delta;
    assign delta = AW'(unit_bytes(width));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= start_addr;
        end else if (step) begin
            case (mode)
                MODE_INC: addr <= addr + delta;
                MODE_DEC: addr <= addr - delta;
                default:  addr <= addr;
            endcase
        end
    end

    a_r4_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode != MODE_INC && mode != MODE_DEC) |=> $stable(addr));

endmodule

// File: rtl/dma_chan_pack.sv
module dma_chan_pack
    import dma_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        push,
    input  logic [1:0]  push_w,
    input  logic [31:0] push_data,
    input  logic        pop,
    input  logic [1:0]  pop_w,
    output logic [31:0] pop_data,
    output logic [2:0]  fill
);

    logic [31:0] hold_q;
    logic [2:0]  n_in, n_out;
    logic [31:0] in_mask, out_mask;

    assign n_in     = unit_bytes(push_w);
    assign n_out    = unit_bytes(pop_w);
    assign in_mask  = (n_in  == 3'd4) ? 32'hFFFF_FFFF : ((32'd1 << {n_in,  3'b000}) - 32'd1);
    assign out_mask = (n_out == 3'd4) ? 32'hFFFF_FFFF : ((32'd1 << {n_out, 3'b000}) - 32'd1);
    assign pop_data = hold_q & out_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            fill   <= '0;
        end else if (clear) begin
            hold_q <= '0;
            fill   <= '0;
        end else if (push) begin
            hold_q <= hold_q | ((push_data & in_mask) << {fill, 3'b000});
            fill   <= fill + n_in;
        end else if (pop) begin
            hold_q <= (n_out == 3'd4) ? 32'd0 : (hold_q >> {n_out, 3'b000});
            fill   <= fill - n_out;
        end
    end

    a_r3_hold_cap: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= 3'd4);
    a_r3_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clear) |-> (fill >= n_out));

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int BSIZE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BSIZE_W-1:0] bsize,
    input  logic [1:0]         src_w,
    input  logic [1:0]         dst_w,
    input  logic               src_ok,
    input  logic               dst_ok,
    input  logic [2:0]         fill,
    input  logic               mem_ack,
    output logic               mem_req,
    output logic               mem_we,
    output logic               rd_ack,
    output logic               wr_ack,
    output logic               done
);

    localparam int CW = BSIZE_W + 3;

    chan_state_e state_q, state_d;
    logic [BSIZE_W-1:0] src_left;
    logic [CW-1:0]      dst_left;
    logic [2:0]         sb, db;
    logic               last_wr, can_wr, can_rd;

    assign sb      = unit_bytes(src_w);
    assign db      = unit_bytes(dst_w);
    assign last_wr = (dst_left == CW'(db));
    assign can_wr  = (fill >= db) && dst_ok;
    assign can_rd  = (src_left != '0) && (({1'b0, fill} + {1'b0, sb}) <= 4'd4) && src_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ARB;
            ST_ARB: begin
                if (dst_left == '0) state_d = ST_IDLE;
                else if (can_wr)    state_d = ST_WR;
                else if (can_rd)    state_d = ST_RD;
            end
            ST_RD: if (mem_ack) state_d = ST_ARB;
            ST_WR: if (mem_ack) state_d = last_wr ? ST_IDLE : ST_ARB;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        mem_req = (state_q == ST_RD) || (state_q == ST_WR);
        mem_we  = (state_q == ST_WR);
        rd_ack  = (state_q == ST_RD) && mem_ack;
        wr_ack  = (state_q == ST_WR) && mem_ack;
        done    = (wr_ack && last_wr) || ((state_q == ST_ARB) && (dst_left == '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_left <= '0;
            dst_left <= '0;
        end else if (start) begin
            src_left <= bsize;
            dst_left <= CW'(bsize) * CW'(sb);
        end else begin
            if (rd_ack) src_left <= src_left - 1'b1;
            if (wr_ack) dst_left <= dst_left - CW'(db);
        end
    end

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE));
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));

endmodule

// File: rtl/dma_single_chan.sv
module dma_single_chan
    import dma_chan_pkg::*;
#(
    parameter int AW      = 32,
    parameter int BSIZE_W = 12,
    parameter int NPER    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [NPER-1:0] hw_req,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      mem_size,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ack,
    output logic            irq
);

    localparam int PIDX_W = (NPER > 1) ? $clog2(NPER) : 1;

    logic [AW-1:0]      src_start, dst_start;
    logic [BSIZE_W-1:0] bsize;
    logic [1:0]         src_w, dst_w, src_mode, dst_mode, xtype;
    logic               src_hw, dst_hw, start, en, soft_src, soft_dst;
    logic [PIDX_W-1:0]  src_idx, dst_idx;
    logic               src_ok, dst_ok, src_take, dst_take;
    logic               rd_ack, wr_ack, done;
    logic [2:0]         fill;
    logic               src_is_per, dst_is_per, src_line, dst_line;

    logic [AW-1:0] ag_start [2];
    logic [AW-1:0] ag_addr  [2];
    logic [1:0]    ag_mode  [2];
    logic [1:0]    ag_width [2];
    logic          ag_step  [2];

    dma_chan_regs #(.AW(AW), .BSIZE_W(BSIZE_W), .PIDX_W(PIDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_start(src_start), .dst_start(dst_start), .bsize(bsize),
        .src_w(src_w), .dst_w(dst_w), .src_mode(src_mode), .dst_mode(dst_mode),
        .xtype(xtype), .src_hw(src_hw), .dst_hw(dst_hw),
        .src_idx(src_idx), .dst_idx(dst_idx), .start(start), .en(en),
        .soft_src(soft_src), .soft_dst(soft_dst),
        .src_take(src_take), .dst_take(dst_take), .done(done), .irq(irq)
    );

    // pacing: bit1 of the type marks the source as peripheral, bit0 the destination
    assign src_is_per = xtype[1];
    assign dst_is_per = xtype[0];
    assign src_line   = hw_req[src_idx];
    assign dst_line   = hw_req[dst_idx];
    assign src_ok     = !src_is_per || (src_hw ? src_line : soft_src);
    assign dst_ok     = !dst_is_per || (dst_hw ? dst_line : soft_dst);
    assign src_take   = rd_ack && src_is_per && !src_hw;
    assign dst_take   = wr_ack && dst_is_per && !dst_hw;

    dma_chan_ctrl #(.BSIZE_W(BSIZE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .bsize(bsize),
        .src_w(src_w), .dst_w(dst_w), .src_ok(src_ok), .dst_ok(dst_ok),
        .fill(fill), .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we),
        .rd_ack(rd_ack), .wr_ack(wr_ack), .done(done)
    );

    assign ag_start[0] = src_start;  assign ag_start[1] = dst_start;
    assign ag_mode[0]  = src_mode;   assign ag_mode[1]  = dst_mode;
    assign ag_width[0] = src_w;      assign ag_width[1] = dst_w;
    assign ag_step[0]  = rd_ack;     assign ag_step[1]  = wr_ack;

    for (genvar g = 0; g < 2; g++) begin : g_side
        dma_chan_addr_gen #(.AW(AW)) u_ag (
            .clk(clk), .rst_n(rst_n), .load(start), .start_addr(ag_start[g]),
            .step(ag_step[g]), .mode(ag_mode[g]), .width(ag_width[g]),
            .addr(ag_addr[g])
        );
    end

    dma_chan_pack u_pack (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .push(rd_ack), .push_w(src_w), .push_data(mem_rdata),
        .pop(wr_ack), .pop_w(dst_w), .pop_data(mem_wdata), .fill(fill)
    );

    assign mem_addr = mem_we ? ag_addr[1] : ag_addr[0];
    assign mem_size = mem_we ? dst_w : src_w;

    a_r2_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> en);
    a_r5_src_line: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && !mem_we && src_is_per && src_hw) |-> $past(src_line));
    a_r5_dst_line: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_we && dst_is_per && dst_hw) |-> $past(dst_line));
    a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata)));
    a_r7_mem_side_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_is_per && !dst_is_per && en) |-> (src_ok && dst_ok));

endmodule

// File: tb/tb_dma_single_chan.sv
`timescale 1ns/100ps
module tb_dma_single_chan;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [15:0] hw_req;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, n_unstable = 0;

    logic [7:0] mem     [0:255];
    logic [7:0] init_m  [0:255];
    logic [7:0] exp_m   [0:255];

    always #2.5 clk = ~clk;

    dma_single_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_req(hw_req), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
    );

    // memory responder with random wait states
    logic        pend = 1'b0;
    int          wcnt = 0;
    logic [31:0] lat_addr, lat_data;
    logic        lat_we;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; pend = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0; pend = 1'b0;
        end else if (mem_req) begin
            if (!pend) begin
                pend = 1'b1; lat_addr = mem_addr; lat_we = mem_we; lat_data = mem_wdata;
                wcnt = int'($urandom_range(0, 2));
            end else if (mem_addr !== lat_addr || mem_we !== lat_we ||
                         (mem_we && mem_wdata !== lat_data)) begin
                n_unstable++;
            end
            if (wcnt == 0) begin
                mem_rdata = 32'd0;
                for (int b = 0; b < (1 << mem_size) && b < 4; b++) begin
                    if (mem_we) mem[8'(mem_addr + 32'(b))] = mem_wdata[8*b +: 8];
                    else        mem_rdata[8*b +: 8] = mem[8'(mem_addr + 32'(b))];
                end
                if (mem_we) n_wr++; else n_rd++;
                mem_ack = 1'b1;
            end else begin
                wcnt--;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic int wbytes(input int w);
        return (w == 0) ? 1 : (w == 1) ? 2 : 4;
    endfunction

    function automatic int first_addr(input int base, input int mode, input int nb);
        return (mode == 1) ? base + 16 - nb : base;
    endfunction

    function automatic int next_addr(input int a, input int mode, input int nb);
        return (mode == 0) ? a + nb : (mode == 1) ? a - nb : a;
    endfunction

    // prepares memory and expected image, programs the channel (not enabled)
    task automatic setup(input int sw, input int dw, input int sm, input int dm,
                         input int total, input int ftype, input logic [31:0] hs);
        logic [7:0] stream [0:15];
        int sb, db, sa, da, k, bsz;
        logic [31:0] d;
        sb = wbytes(sw); db = wbytes(dw); bsz = total / sb;
        for (int i = 0; i < 256; i++) begin
            init_m[i] = 8'((i * 37 + 11) & 255);
            mem[i] = init_m[i]; exp_m[i] = init_m[i];
        end
        sa = first_addr(32'h10, sm, sb); k = 0;
        for (int u = 0; u < bsz; u++) begin
            for (int b = 0; b < sb; b++) begin stream[k] = init_m[sa + b]; k++; end
            sa = next_addr(sa, sm, sb);
        end
        da = first_addr(32'h80, dm, db); k = 0;
        for (int u = 0; u < total / db; u++) begin
            for (int b = 0; b < db; b++) begin exp_m[da + b] = stream[k]; k++; end
            da = next_addr(da, dm, db);
        end
        reg_write(3'd0, 32'(first_addr(32'h10, sm, sb)));
        reg_write(3'd1, 32'(first_addr(32'h80, dm, db)));
        reg_write(3'd2, (32'd3 << 22) | (32'(ftype) << 20) | (32'(dm) << 18) |
                        (32'(sm) << 16) | (32'(dw) << 14) | (32'(sw) << 12) | 32'(bsz));
        reg_write(3'd3, hs);
        reg_read(3'd6, d);
        n_rd = 0; n_wr = 0;
    endtask

    task automatic wait_irq(input int lim);
        for (int c = 0; c < lim; c++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic cmp_mem(input string tag);
        int bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) bad++;
        chk(tag, 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int ones, after;
        void'($urandom(32'd7321));
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
        reg_wdata = '0; hw_req = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        reg_read(3'd4, d); chk("R1 enable", d, 32'd0);
        reg_read(3'd6, d); chk("R1 flag", d, 32'd0);

        // R2 enable refused with only one descriptor-disable bit set
        setup(2, 2, 0, 0, 8, 0, 32'd0);
        reg_write(3'd2, (32'd1 << 22) | (32'd2 << 14) | (32'd2 << 12) | 32'd2);
        reg_write(3'd4, 32'd1);
        repeat (20) @(negedge clk);
        reg_read(3'd4, d); chk("R2 enable refused", d, 32'd0);
        chk("R2 no accesses", 32'(n_rd + n_wr), 32'd0);
        chk("R2 irq low", 32'(irq), 32'd0);

        // R3 R4 R7 R8 R9: random widths and modes, memory sides with noise in handshake fields
        for (int t = 0; t < 16; t++) begin
            int sw, dw, sm, dm, total;
            sw = int'($urandom_range(0, 2)); dw = int'($urandom_range(0, 2));
            sm = int'($urandom_range(0, 2)); dm = int'($urandom_range(0, 2));
            if (t == 0) begin sw = 0; dw = 2; sm = 0; dm = 1; end
            if (t == 1) begin sw = 2; dw = 0; sm = 1; dm = 0; end
            if (t == 2) begin sw = 1; dw = 2; sm = 2; dm = 0; end
            total = 4 * int'($urandom_range(1, 4));
            setup(sw, dw, sm, dm, total, 0, 32'h0000_0FF3);
            reg_write(3'd4, 32'd1);
            reg_read(3'd4, d); chk("R8 enable busy", d, 32'd1);
            wait_irq(800);
            chk("R8 irq at completion", 32'(irq), 32'd1);
            reg_read(3'd4, d); chk("R8 enable cleared", d, 32'd0);
            reg_read(3'd6, d); chk("R9 flag read", d, 32'd1);
            reg_read(3'd6, d); chk("R9 flag cleared", d, 32'd0);
            chk("R9 irq cleared", 32'(irq), 32'd0);
            cmp_mem("R3/R4 copy image");
            chk("R3 write count", 32'(n_wr), 32'(total / wbytes(dw)));
        end

        // R5 hardware pacing of a peripheral source on line 3
        setup(0, 2, 2, 0, 4, 2, 32'h0000_0031);
        hw_req = 16'h0004;
        reg_write(3'd4, 32'd1);
        repeat (30) @(negedge clk);
        chk("R5 other line ignored", 32'(n_rd), 32'd0);
        hw_req = 16'h0008;
        wait_irq(800);
        hw_req = 16'h0000;
        chk("R5 paced completion", 32'(irq), 32'd1);
        cmp_mem("R5 paced copy image");
        reg_read(3'd6, d);

        // R6 software pacing of a peripheral destination
        setup(2, 2, 0, 0, 8, 1, 32'h0000_0000);
        reg_write(3'd4, 32'd1);
        repeat (30) @(negedge clk);
        chk("R6 no write without request", 32'(n_wr), 32'd0);
        reg_write(3'd5, 32'd2);
        repeat (30) @(negedge clk);
        chk("R6 one write per request", 32'(n_wr), 32'd1);
        reg_write(3'd5, 32'd2);
        wait_irq(100);
        repeat (2) @(negedge clk);
        chk("R6 second request", 32'(n_wr), 32'd2);
        chk("R6 done", 32'(irq), 32'd1);
        cmp_mem("R6 copy image");
        reg_read(3'd6, d);

        // R9 completion coinciding with a status read: continuous polling
        setup(1, 0, 0, 1, 8, 0, 32'd0);
        reg_write(3'd4, 32'd1);
        ones = 0; after = 0;
        @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd6;
        for (int c = 0; c < 600; c++) begin
            #1;
            if (reg_rdata[0]) ones++;
            if (ones > 0) after++;
            if (after > 6) break;
            @(negedge clk);
        end
        @(negedge clk); reg_rd = 1'b0;
        chk("R9 set wins over same-cycle read", 32'(ones), 32'd1);
        chk("R9 irq low after polling", 32'(irq), 32'd0);
        cmp_mem("R9 copy image");

        // R10 bus hold
        chk("R10 request stable until ack", 32'(n_unstable), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule